// File: doc/BRIEF.md
# Ternary Level-to-Gate Encoder

This block sits between a waveform generator and the gate drivers of a cascaded multilevel inverter. The inverter stacks five three-switch cells and finishes with a four-switch polarity bridge. Each cell can insert nothing, a unit voltage, or twice that unit voltage. The unit voltages of the cells rise in powers of three (1, 3, 9, 27, 81). Together the cells give every magnitude from 0 to 242, and the bridge gives the sign, so 485 distinct output levels are possible.

On a strobe, the encoder accepts a signed level request. It first takes the magnitude and clamps it to the largest value the cells can build. It then splits the magnitude into five base-3 digits and turns each digit into a one-hot choice among the three switches of its cell. The sign selects which diagonal pair of the bridge conducts. All 19 gate enables are registered and hold their value between strobes. The result appears two clock edges after the strobe is sampled. A one-cycle flag reports any request whose magnitude had to be clamped.

Top module: `tern_gate_enc`

## Requirements
- R1: While `rst_n` is low, every cell field of `gate_cell` is `3'b010`, `gate_bridge` is `4'b0011` and `clamp_flag` is 0.
- R2: Each 3-bit cell field of `gate_cell` always has exactly one bit set.
- R3: Cell j (j = 0..4) occupies bits [3j+2:3j] of `gate_cell`. Digit value 0 sets bit 1 of the field (zero leg), digit 1 sets bit 0 (single-weight leg) and digit 2 sets bit 2 (double-weight leg).
- R4: Cell 0 carries the least significant base-3 digit of the magnitude and cell 4 the most significant. For example, magnitude 169 (base 3: 20021) gives fields, from cell 4 down to cell 0, of 100, 010, 010, 100, 001.
- R5: A request of zero or above drives `gate_bridge` = `4'b0011`; a negative request drives `4'b1100`. A negative request drives the same cell fields as its absolute value.
- R6: A request whose magnitude exceeds 242 produces the cell fields of 242 (all fields `3'b100`), keeps its sign on the bridge, and raises `clamp_flag`.
- R7: `clamp_flag` is high for exactly one cycle, in the same cycle that the outputs of the clamped request appear. It is low for every request in range.
- R8: A strobe sampled at rising edge E changes the outputs at edge E+1 of the next clock edge after that, so the new values show after the second rising edge. After the first rising edge the outputs still show the previous request.
- R9: When no strobe is applied, `gate_cell` and `gate_bridge` hold their values whatever `lvl_req` does. Back-to-back strobes are each applied in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_stb | input | 1 | Strobe: `lvl_req` is valid this cycle |
| lvl_req | input | 10 | Requested level, two's complement |
| gate_cell | output | 15 | One-hot switch enables, three per cell |
| gate_bridge | output | 4 | Bridge enables: [1:0] positive pair, [3:2] negative pair |
| clamp_flag | output | 1 | One-cycle pulse: request magnitude was clamped |

## Verification
The hardest cases to reach from the ports are the extreme clamped requests, such as -512, where negating the two's complement input must still give a magnitude above the limit rather than wrapping. The stimulus table therefore covers magnitudes just inside and just outside the limit, for both signs, alongside every digit value in every cell position. The flag pulse is also hard to observe, because two strobes in a row could stretch or hide it. Directed tests issue a clamped request followed at once by an in-range one, and then sample the flag in each of the following cycles.

// File: rtl/tge_pkg.sv
package tge_pkg;
  // bit positions inside one cell field
  localparam int LEG_ONE  = 0;
  localparam int LEG_ZERO = 1;
  localparam int LEG_TWO  = 2;

  localparam logic [2:0] FIELD_ZERO = 3'b010;
  localparam logic [2:0] FIELD_ONE  = 3'b001;
  localparam logic [2:0] FIELD_TWO  = 3'b100;

  localparam logic [3:0] BRIDGE_POS = 4'b0011;
  localparam logic [3:0] BRIDGE_NEG = 4'b1100;

  typedef enum logic [1:0] {
    TDIG_0 = 2'd0,
    TDIG_1 = 2'd1,
    TDIG_2 = 2'd2
  } tdig_e;
endpackage

// File: rtl/tge_mag_sat.sv
module tge_mag_sat #(
  parameter int LVL_W   = 10,
  parameter int MAG_W   = 8,
  parameter int MAX_MAG = 242
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             s1_vld,
  output logic             s1_neg,
  output logic             s1_clamp,
  output logic [MAG_W-1:0] s1_mag
);
  logic             neg_d;
  logic [LVL_W-1:0] abs_d;
  logic             clamp_d;
  logic [MAG_W-1:0] mag_d;

  always_comb begin
    neg_d   = lvl_i[LVL_W-1];
    abs_d   = neg_d ? (~lvl_i + 1'b1) : lvl_i;
    clamp_d = (abs_d > LVL_W'(MAX_MAG));
    mag_d   = clamp_d ? MAG_W'(MAX_MAG) : abs_d[MAG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_neg   <= 1'b0;
      s1_clamp <= 1'b0;
      s1_mag   <= '0;
    end else begin
      s1_vld <= stb_i;
      if (stb_i) begin
        s1_neg   <= neg_d;
        s1_clamp <= clamp_d;
        s1_mag   <= mag_d;
      end
    end
  end

  AST_MAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (s1_mag <= MAG_W'(MAX_MAG))); // R6
endmodule

// File: rtl/tge_tern_digits.sv
module tge_tern_digits #(
  parameter int N_CELLS = 5,
  parameter int MAG_W   = 8
) (
  input  logic [MAG_W-1:0]     mag_i,
  output logic [2*N_CELLS-1:0] dig_o
);
  logic [MAG_W-1:0] quo [N_CELLS];

  assign quo[0] = mag_i;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_dig
    assign dig_o[2*i +: 2] = 2'(quo[i] % MAG_W'(3));
    if (i < N_CELLS - 1) begin : g_div
      assign quo[i+1] = quo[i] / MAG_W'(3);
    end
  end
endmodule

// File: rtl/tge_leg_select.sv
module tge_leg_select
  import tge_pkg::*;
#(
  parameter int N_CELLS = 5
) (
  input  logic [2*N_CELLS-1:0] dig_i,
  output logic [3*N_CELLS-1:0] field_o
);
  for (genvar j = 0; j < N_CELLS; j++) begin : g_cell
    tdig_e d;
    assign d = tdig_e'(dig_i[2*j +: 2]);
    always_comb begin
      case (d)
        TDIG_0:  field_o[3*j +: 3] = FIELD_ZERO;
        TDIG_1:  field_o[3*j +: 3] = FIELD_ONE;
        TDIG_2:  field_o[3*j +: 3] = FIELD_TWO;
        default: field_o[3*j +: 3] = 3'b000;
      endcase
    end
  end
endmodule

// File: rtl/tern_gate_enc.sv
module tern_gate_enc
  import tge_pkg::*;
#(
  parameter int N_CELLS = 5,
  parameter int LVL_W   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lvl_stb,
  input  logic [LVL_W-1:0]     lvl_req,
  output logic [3*N_CELLS-1:0] gate_cell,
  output logic [3:0]           gate_bridge,
  output logic                 clamp_flag
);
  localparam int MAX_MAG = 3**N_CELLS - 1;
  localparam int MAG_W   = $clog2(MAX_MAG + 1);
  localparam int CELL_W  = 3 * N_CELLS;

  logic             s1_vld, s1_neg, s1_clamp;
  logic [MAG_W-1:0] s1_mag;
  logic [2*N_CELLS-1:0] digits;
  logic [CELL_W-1:0]    fields;

  logic [CELL_W-1:0] cell_d;
  logic [3:0]        bridge_d;
  logic              clamp_d;

  tge_mag_sat #(.LVL_W(LVL_W), .MAG_W(MAG_W), .MAX_MAG(MAX_MAG)) u_sat (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb_i    (lvl_stb),
    .lvl_i    (lvl_req),
    .s1_vld   (s1_vld),
    .s1_neg   (s1_neg),
    .s1_clamp (s1_clamp),
    .s1_mag   (s1_mag)
  );

  tge_tern_digits #(.N_CELLS(N_CELLS), .MAG_W(MAG_W)) u_dig (
    .mag_i (s1_mag),
    .dig_o (digits)
  );

  tge_leg_select #(.N_CELLS(N_CELLS)) u_leg (
    .dig_i   (digits),
    .field_o (fields)
  );

  always_comb begin
    cell_d   = gate_cell;
    bridge_d = gate_bridge;
    clamp_d  = 1'b0;
    if (s1_vld) begin
      cell_d   = fields;
      bridge_d = s1_neg ? BRIDGE_NEG : BRIDGE_POS;
      clamp_d  = s1_clamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_cell   <= {N_CELLS{FIELD_ZERO}};
      gate_bridge <= BRIDGE_POS;
      clamp_flag  <= 1'b0;
    end else begin
      gate_cell   <= cell_d;
      gate_bridge <= bridge_d;
      clamp_flag  <= clamp_d;
    end
  end

  for (genvar j = 0; j < N_CELLS; j++) begin : g_chk
    AST_CELL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gate_cell[3*j +: 3]) == 1); // R2
  end

  AST_BRIDGE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_bridge == BRIDGE_POS) || (gate_bridge == BRIDGE_NEG)); // R5

  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> ($stable(gate_cell) && $stable(gate_bridge))); // R9

  AST_CLAMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_flag |-> $past(s1_vld)); // R7

  AST_CLAMP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_flag |-> (gate_cell == {N_CELLS{FIELD_TWO}})); // R6
endmodule

// File: tb/sim_tern_gate_enc.sv
`timescale 1ns/1ps
module sim_tern_gate_enc;
  localparam int VN = 17;
  localparam int VLVL  [VN] = '{0, 1, 2, 3, 80, 81, 100, 121, 169, 242,
                                -1, -169, -242, 243, -300, 511, -512};
  localparam int VCODE [VN] = '{0, 1, 2, 10, 2222, 10000, 10201, 11111, 20021, 22222,
                                1, 20021, 22222, 22222, 22222, 22222, 22222};
  localparam int VCLMP [VN] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                0, 0, 0, 1, 1, 1, 1};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lvl_stb;
  logic [9:0]  lvl_req;
  logic [14:0] gate_cell;
  logic [3:0]  gate_bridge;
  logic        clamp_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tern_gate_enc u0 (
    .clk(clk), .rst_n(rst_n), .lvl_stb(lvl_stb), .lvl_req(lvl_req),
    .gate_cell(gate_cell), .gate_bridge(gate_bridge), .clamp_flag(clamp_flag)
  );

  function automatic logic [14:0] cells_of(input int code);
    logic [14:0] f;
    int c;
    c = code;
    for (int d = 0; d < 5; d++) begin
      case (c % 10)
        0: f[3*d +: 3] = 3'b010;
        1: f[3*d +: 3] = 3'b001;
        default: f[3*d +: 3] = 3'b100;
      endcase
      c = c / 10;
    end
    return f;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input int lvl);
    @(negedge clk);
    lvl_stb = 1'b1;
    lvl_req = 10'(lvl);
    @(negedge clk);
    lvl_stb = 1'b0;
    lvl_req = 10'h155;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lvl_stb = 1'b0; lvl_req = '0;
    repeat (3) @(negedge clk);
    chk("R1 cells", 32'(gate_cell), 32'(cells_of(0)));
    chk("R1 bridge", 32'(gate_bridge), 32'h3);
    chk("R1 flag", 32'(clamp_flag), 32'h0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < VN; i++) begin
      strobe(VLVL[i]);
      @(negedge clk);
      chk("R3 R4 cells", 32'(gate_cell), 32'(cells_of(VCODE[i])));
      chk("R5 bridge", 32'(gate_bridge), (VLVL[i] < 0) ? 32'hC : 32'h3);
      chk("R6 R7 flag", 32'(clamp_flag), 32'(VCLMP[i]));
      @(negedge clk);
      chk("R7 flag drops", 32'(clamp_flag), 32'h0);
    end

    // R8: latency, old value after first edge
    strobe(0);
    @(negedge clk);
    strobe(242);
    chk("R8 old after one edge", 32'(gate_cell), 32'(cells_of(0)));
    @(negedge clk);
    chk("R8 new after two edges", 32'(gate_cell), 32'(cells_of(22222)));

    // R9: hold while lvl_req wanders without strobe
    strobe(-169);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      lvl_req = 10'(k * 37 + 5);
      @(negedge clk);
    end
    chk("R9 hold cells", 32'(gate_cell), 32'(cells_of(20021)));
    chk("R9 hold bridge", 32'(gate_bridge), 32'hC);

    // R9 back-to-back, R7 clamp then in-range
    @(negedge clk);
    lvl_stb = 1'b1; lvl_req = 10'(300);
    @(negedge clk);
    lvl_req = 10'(5);
    @(negedge clk);
    lvl_stb = 1'b0;
    chk("R6 b2b clamp cells", 32'(gate_cell), 32'(cells_of(22222)));
    chk("R7 b2b flag high", 32'(clamp_flag), 32'h1);
    @(negedge clk);
    chk("R9 b2b second", 32'(gate_cell), 32'(cells_of(12)));
    chk("R7 b2b flag low", 32'(clamp_flag), 32'h0);

    // R1: reset mid-run
    strobe(-242);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async cells", 32'(gate_cell), 32'(cells_of(0)));
    chk("R1 async bridge", 32'(gate_bridge), 32'h3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule